// File: doc/BRIEF.md
# TLB Replacement Pointer Unit

This block keeps the three pieces of pointer state that decide which slot of a 32-slot translation buffer gets written. The first is an index register that software loads, or that a lookup probe updates; it carries a failure flag for the last probe. The second is a replacement pointer that software can only read. It steps down by one for every retired instruction. The third is a boundary register that reserves the lowest slots so they are never picked for random replacement.

The surrounding logic writes the registers through one select/data/strobe port and reads them back through a combinational read mux on the same select. It pulses a retire input once per completed instruction. It reports each probe outcome with a strobe, a hit flag and the matching slot. The indexed-write slot and the random-write slot are brought out on their own buses so the buffer array can use them directly.

Top module: `tlbp_unit`

## Requirements
- R1: After synchronous reset the index field is 0, the failure flag is 0, the boundary register is 0 and the replacement pointer is 31.
- R2: A write with select 0 loads the index field from data bits 5:0 and the failure flag from data bit 31. The new values are visible on the next cycle, both on read data and on `idx_entry`.
- R3: A probe strobe with hit set clears the failure flag and loads the index field from `probe_idx`.
- R4: A probe strobe with hit clear sets the failure flag and leaves the index field unchanged.
- R5: Each cycle with `retire` high lowers the replacement pointer by one. Without `retire`, and without a boundary write, the pointer holds its value.
- R6: When `retire` is high and the pointer equals the lower bound, the pointer reloads to 31 instead of stepping down.
- R7: A write with select 2 loads the boundary register from data bits 5:0 and forces the pointer to 31. This also holds when `retire` is high in the same cycle.
- R8: A boundary value above 31 is treated as a lower bound of 31, so the pointer stays at 31 while instructions retire.
- R9: A write with select 1 has no effect on the replacement pointer.
- R10: Select 3 reads as zero, and a write to it changes no register.
- R11: The read layout is as follows. Select 0 returns the failure flag in bit 31 and the index field in bits 5:0. Select 1 returns the pointer in bits 5:0. Select 2 returns the boundary in bits 5:0. All other bits read as zero.
- R12: When a probe strobe and a select-0 write fall in the same cycle, the probe result is the one stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 2 | Register select for both read and write (0 index, 1 pointer, 2 boundary, 3 none) |
| reg_wdata | input | 32 | Write data |
| reg_we | input | 1 | Write strobe |
| retire | input | 1 | One pulse per retired instruction |
| probe_vld | input | 1 | Probe result strobe |
| probe_hit | input | 1 | Probe found a match |
| probe_idx | input | 6 | Slot that matched |
| reg_rdata | output | 32 | Read data for `reg_sel` |
| idx_entry | output | 6 | Slot for indexed writes |
| rnd_entry | output | 6 | Slot for random writes |

## Verification
The hardest cases to reach are the reload at the lower bound and a boundary write that collides with a retire pulse. The bench sets a boundary near the top, then counts retire pulses until the pointer lands exactly on the bound, and it checks the reload on the next pulse. It also asserts a boundary write and `retire` in the same cycle. It then sets the boundary to zero and runs the pointer through the full 32-step cycle. Finally it drives a boundary above 31 to confirm the pointer is held at the top.

// File: rtl/tlbp_pkg.sv
package tlbp_pkg;
    localparam int ENTRIES = 32;
    localparam int FLD_W   = 6;
    localparam int DATA_W  = 32;
    localparam logic [FLD_W-1:0] TOP_SLOT = FLD_W'(ENTRIES - 1);

    typedef enum logic [1:0] {
        SEL_INDEX  = 2'd0,
        SEL_RANDOM = 2'd1,
        SEL_WIRED  = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic             fail;
        logic [FLD_W-1:0] slot;
    } idx_reg_t;

    function automatic logic [FLD_W-1:0] lower_bound(input logic [FLD_W-1:0] wired);
        return (wired > TOP_SLOT) ? TOP_SLOT : wired;
    endfunction
endpackage

// File: rtl/tlbp_index_reg.sv
module tlbp_index_reg
    import tlbp_pkg::*;
#(
    parameter int W = FLD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sw_wr,
    input  logic         sw_fail,
    input  logic [W-1:0] sw_slot,
    input  logic         probe_vld,
    input  logic         probe_hit,
    input  logic [W-1:0] probe_idx,
    output logic         fail_q,
    output logic [W-1:0] slot_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            fail_q <= 1'b0;
            slot_q <= '0;
        end else if (probe_vld) begin
            if (probe_hit) begin
                fail_q <= 1'b0;
                slot_q <= probe_idx;
            end else begin
                fail_q <= 1'b1;
            end
        end else if (sw_wr) begin
            fail_q <= sw_fail;
            slot_q <= sw_slot;
        end
    end
endmodule

// File: rtl/tlbp_wired_reg.sv
module tlbp_wired_reg
    import tlbp_pkg::*;
#(
    parameter int W = FLD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] wired_q,
    output logic [W-1:0] bound
);
    always_ff @(posedge clk) begin
        if (rst)     wired_q <= '0;
        else if (wr) wired_q <= wdata;
    end

    assign bound = lower_bound(wired_q);
endmodule

// File: rtl/tlbp_random_ctr.sv
module tlbp_random_ctr
    import tlbp_pkg::*;
#(
    parameter int W = FLD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wired_wr,
    input  logic         retire,
    input  logic [W-1:0] bound,
    output logic [W-1:0] rnd_q
);
    logic at_floor;
    assign at_floor = (rnd_q <= bound);

    always_ff @(posedge clk) begin
        if (rst)           rnd_q <= TOP_SLOT;
        else if (wired_wr) rnd_q <= TOP_SLOT;
        else if (retire)   rnd_q <= at_floor ? TOP_SLOT : rnd_q - 1'b1;
    end
endmodule

// File: rtl/tlbp_unit.sv
module tlbp_unit
    import tlbp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_we,
    input  logic              retire,
    input  logic              probe_vld,
    input  logic              probe_hit,
    input  logic [FLD_W-1:0]  probe_idx,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [FLD_W-1:0]  idx_entry,
    output logic [FLD_W-1:0]  rnd_entry
);
    reg_sel_e         sel;
    idx_reg_t         idx_q;
    logic [FLD_W-1:0] wired_val;
    logic [FLD_W-1:0] bound;
    logic             wr_index, wr_wired;
    logic             unused_wbits;

    assign sel          = reg_sel_e'(reg_sel);
    assign wr_index     = reg_we && (sel == SEL_INDEX);
    assign wr_wired     = reg_we && (sel == SEL_WIRED);
    assign unused_wbits = ^reg_wdata[DATA_W-2:FLD_W];

    tlbp_index_reg #(.W(FLD_W)) u_index (
        .clk       (clk),
        .rst       (rst),
        .sw_wr     (wr_index),
        .sw_fail   (reg_wdata[DATA_W-1]),
        .sw_slot   (reg_wdata[FLD_W-1:0]),
        .probe_vld (probe_vld),
        .probe_hit (probe_hit),
        .probe_idx (probe_idx),
        .fail_q    (idx_q.fail),
        .slot_q    (idx_q.slot)
    );

    tlbp_wired_reg #(.W(FLD_W)) u_wired (
        .clk     (clk),
        .rst     (rst),
        .wr      (wr_wired),
        .wdata   (reg_wdata[FLD_W-1:0]),
        .wired_q (wired_val),
        .bound   (bound)
    );

    tlbp_random_ctr #(.W(FLD_W)) u_random (
        .clk      (clk),
        .rst      (rst),
        .wired_wr (wr_wired),
        .retire   (retire),
        .bound    (bound),
        .rnd_q    (rnd_entry)
    );

    assign idx_entry = idx_q.slot;

    always_comb begin
        reg_rdata = '0;
        unique case (sel)
            SEL_INDEX: begin
                reg_rdata[DATA_W-1]  = idx_q.fail;
                reg_rdata[FLD_W-1:0] = idx_q.slot;
            end
            SEL_RANDOM: reg_rdata[FLD_W-1:0] = rnd_entry;
            SEL_WIRED:  reg_rdata[FLD_W-1:0] = wired_val;
            SEL_NONE:   reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/tlbp_chk.sv
module tlbp_chk
    import tlbp_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [1:0]        reg_sel,
    input logic              reg_we,
    input logic              retire,
    input logic              probe_vld,
    input logic              probe_hit,
    input logic [FLD_W-1:0]  probe_idx,
    input logic [DATA_W-1:0] reg_rdata,
    input logic [FLD_W-1:0]  idx_entry,
    input logic [FLD_W-1:0]  rnd_entry,
    input logic [FLD_W-1:0]  wired_val
);
    logic wwr;
    assign wwr = reg_we && (reg_sel == 2'd2);

    p_reset_r1: assert property (@(posedge clk) rst |=> (rnd_entry == TOP_SLOT) && (idx_entry == '0) && (wired_val == '0));

    p_range_r8: assert property (@(posedge clk) disable iff (rst)
        (rnd_entry <= TOP_SLOT) && (rnd_entry >= lower_bound(wired_val)));

    p_step_r5: assert property (@(posedge clk) disable iff (rst)
        (retire && !wwr && rnd_entry != lower_bound(wired_val)) |=> rnd_entry == $past(rnd_entry) - 1'b1);

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!retire && !wwr) |=> $stable(rnd_entry));

    p_wrap_r6: assert property (@(posedge clk) disable iff (rst)
        (retire && !wwr && rnd_entry == lower_bound(wired_val)) |=> rnd_entry == TOP_SLOT);

    p_wired_top_r7: assert property (@(posedge clk) disable iff (rst)
        wwr |=> rnd_entry == TOP_SLOT);

    p_hit_r3: assert property (@(posedge clk) disable iff (rst)
        (probe_vld && probe_hit) |=> idx_entry == $past(probe_idx));

    p_miss_r4: assert property (@(posedge clk) disable iff (rst)
        (probe_vld && !probe_hit) |=> $stable(idx_entry));

    p_unused_r10: assert property (@(posedge clk) disable iff (rst)
        (reg_sel == 2'd3) |-> reg_rdata == '0);
endmodule

bind tlbp_unit tlbp_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_sel   (reg_sel),
    .reg_we    (reg_we),
    .retire    (retire),
    .probe_vld (probe_vld),
    .probe_hit (probe_hit),
    .probe_idx (probe_idx),
    .reg_rdata (reg_rdata),
    .idx_entry (idx_entry),
    .rnd_entry (rnd_entry),
    .wired_val (wired_val)
);

// File: tb/tb_tlbp_unit.sv
module tb_tlbp_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  reg_sel;
    logic [31:0] reg_wdata;
    logic        reg_we, retire, probe_vld, probe_hit;
    logic [5:0]  probe_idx;
    logic [31:0] reg_rdata;
    logic [5:0]  idx_entry, rnd_entry;

    int checks = 0;
    int failures = 0;

    // reference state derived from the requirements
    logic       m_fail;
    logic [5:0] m_idx, m_wired, m_rnd;

    typedef struct {
        int          kind;   // 0 read data, 1 idx_entry, 2 rnd_entry
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];
    bit    done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tlbp_unit dut (
        .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .retire(retire), .probe_vld(probe_vld),
        .probe_hit(probe_hit), .probe_idx(probe_idx), .reg_rdata(reg_rdata),
        .idx_entry(idx_entry), .rnd_entry(rnd_entry)
    );

    // monitor: compares queued expectations a quarter period after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_PERIOD/4);
            while (sb.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = sb.pop_front();
                act = (it.kind == 0) ? reg_rdata :
                      (it.kind == 1) ? {26'd0, idx_entry} : {26'd0, rnd_entry};
                checks++;
                if (act !== it.exp) begin
                    failures++;
                    $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic push(input int kind, input logic [31:0] exp, input string tag);
        item_t it;
        it.kind = kind; it.exp = exp; it.tag = tag;
        sb.push_back(it);
    endtask

    // one stimulus cycle, with the reference updated per the requirements
    task automatic cyc(input logic we, input logic [1:0] sel, input logic [31:0] wd,
                       input logic ret, input logic pv, input logic ph, input logic [5:0] pi);
        logic [5:0] b;
        @(negedge clk);
        reg_we = we; reg_sel = sel; reg_wdata = wd;
        retire = ret; probe_vld = pv; probe_hit = ph; probe_idx = pi;
        if (pv) begin
            if (ph) begin m_fail = 1'b0; m_idx = pi; end
            else m_fail = 1'b1;
        end else if (we && sel == 2'd0) begin
            m_fail = wd[31]; m_idx = wd[5:0];
        end
        b = (m_wired > 6'd31) ? 6'd31 : m_wired;
        if (we && sel == 2'd2) begin
            m_wired = wd[5:0]; m_rnd = 6'd31;
        end else if (ret) begin
            m_rnd = (m_rnd == b) ? 6'd31 : m_rnd - 6'd1;
        end
    endtask

    task automatic idle_sel(input logic [1:0] sel);
        @(negedge clk);
        reg_we = 0; retire = 0; probe_vld = 0; probe_hit = 0; reg_sel = sel;
    endtask

    task automatic chk_read(input logic [1:0] sel, input logic [31:0] exp, input string tag);
        idle_sel(sel);
        push(0, exp, tag);
    endtask

    task automatic chk_model(input string tag);
        chk_read(2'd0, {m_fail, 25'd0, m_idx}, {tag, " R11 index"});
        push(1, {26'd0, m_idx}, {tag, " idx_entry"});
        chk_read(2'd1, {26'd0, m_rnd}, {tag, " R11 pointer"});
        push(2, {26'd0, m_rnd}, {tag, " rnd_entry"});
        chk_read(2'd2, {26'd0, m_wired}, {tag, " R11 boundary"});
    endtask

    initial begin
        rst = 1; reg_we = 0; reg_sel = 0; reg_wdata = 0; retire = 0;
        probe_vld = 0; probe_hit = 0; probe_idx = 0;
        m_fail = 0; m_idx = 0; m_wired = 0; m_rnd = 6'd31;
        repeat (3) @(negedge clk);
        rst = 0;

        // R1 reset state
        chk_read(2'd1, 32'd31, "R1 pointer after reset");
        push(1, 32'd0, "R1 idx_entry after reset");
        chk_read(2'd2, 32'd0, "R1 boundary after reset");
        chk_read(2'd3, 32'd0, "R10 unused select");
        chk_model("R1");

        // R2 software index writes
        cyc(1, 2'd0, 32'h8000_0015, 0, 0, 0, 0);
        chk_read(2'd0, 32'h8000_0015, "R2 index with flag");
        cyc(1, 2'd0, 32'h7FFF_FF07, 0, 0, 0, 0);
        chk_read(2'd0, 32'h0000_0007, "R2 index flag clear");

        // R9 pointer is read-only
        cyc(1, 2'd1, 32'h0000_0005, 0, 0, 0, 0);
        chk_read(2'd1, 32'd31, "R9 pointer write ignored");

        // R5 stepping and holding
        for (int i = 0; i < 5; i++) cyc(0, 2'd0, 0, 1, 0, 0, 0);
        chk_read(2'd1, 32'd26, "R5 five steps");
        idle_sel(2'd1); idle_sel(2'd1);
        chk_read(2'd1, 32'd26, "R5 hold without retire");

        // R7 boundary write forces top, R6 reload at the bound
        cyc(1, 2'd2, 32'd28, 0, 0, 0, 0);
        chk_read(2'd1, 32'd31, "R7 boundary write forces top");
        for (int i = 0; i < 3; i++) cyc(0, 2'd0, 0, 1, 0, 0, 0);
        chk_read(2'd1, 32'd28, "R6 reached bound");
        cyc(0, 2'd0, 0, 1, 0, 0, 0);
        chk_read(2'd1, 32'd31, "R6 reload at bound");
        cyc(0, 2'd0, 0, 1, 0, 0, 0);
        cyc(0, 2'd0, 0, 1, 0, 0, 0);
        cyc(1, 2'd2, 32'd10, 1, 0, 0, 0);
        chk_read(2'd1, 32'd31, "R7 boundary write beats retire");
        chk_model("R7");

        // R3, R4 probe outcomes
        cyc(0, 2'd0, 0, 0, 1, 1, 6'd9);
        chk_read(2'd0, 32'h0000_0009, "R3 probe hit");
        cyc(0, 2'd0, 0, 0, 1, 0, 6'd22);
        chk_read(2'd0, 32'h8000_0009, "R4 probe miss");
        push(1, 32'd9, "R4 idx_entry kept");

        // R12 probe over software write
        cyc(1, 2'd0, 32'h0000_0033, 0, 1, 1, 6'd4);
        chk_read(2'd0, 32'h0000_0004, "R12 probe wins");
        cyc(1, 2'd0, 32'h0000_0033, 0, 1, 0, 6'd0);
        chk_read(2'd0, 32'h8000_0004, "R12 miss wins");

        // R8 boundary above the top
        cyc(1, 2'd2, 32'd40, 0, 0, 0, 0);
        for (int i = 0; i < 4; i++) cyc(0, 2'd0, 0, 1, 0, 0, 0);
        chk_read(2'd1, 32'd31, "R8 pointer pinned at top");
        chk_read(2'd2, 32'd40, "R8 boundary readback");

        // R6 full cycle with boundary zero
        cyc(1, 2'd2, 32'd0, 0, 0, 0, 0);
        for (int i = 0; i < 40; i++) begin
            cyc(0, 2'd0, 0, 1, 0, 0, 0);
            chk_model("R6 sweep");
        end

        // R10 writes to unused select
        cyc(1, 2'd3, 32'hFFFF_FFFF, 0, 0, 0, 0);
        chk_read(2'd3, 32'd0, "R10 unused after write");
        chk_model("R10");

        // R1 reset again after activity
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0;
        m_fail = 0; m_idx = 0; m_wired = 0; m_rnd = 6'd31;
        chk_model("R1 second reset");

        idle_sel(2'd0); idle_sel(2'd0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule